// File: doc/BRIEF.md
# Quadratic chaotic map bit generator

This block iterates the quadratic map x(n+1) = r - x(n)^2 in signed fixed point and turns each new iterate into one sampling bit. Every iteration passes through a squaring pipeline and then a saturating subtract pipeline. A threshold stage follows them. The loop is closed, so the next iteration may only start once the previous one has produced its result. One value is in flight at any time. With a consumer that is always ready, a new iterate and its bit therefore appear every thirteen clocks. Each bit is meant as a non-periodic sampling strobe for a downstream entropy sampler.

An iteration takes its operand from a select input. While `seed_sel` is low, each iteration starts from the `seed_x` input. Once `seed_sel` goes high, each iteration starts from the previous result. The usual start-up holds the select low for the first twelve clocks after reset, so that the first iteration loads the seed. The parameter `map_r` and the operand are captured when an iteration starts. Results leave on a valid/ready stream. A result that is not accepted is held unchanged, and no new iteration starts until the result is taken. Back-pressure therefore stretches the iteration period without losing or reordering values.

Top module: `qm_chaos_bitgen`

## Requirements
- R1: Values are signed Q4.28 (32 bits, 28 fraction bits). A result equals r minus the square of the operand. The square is taken from the full 64-bit product, rounded to Q4.28 by adding 2^27 and shifting right arithmetically by 28.
- R2: A rounded square above 0x7FFFFFFF becomes 0x7FFFFFFF. A difference below 0x80000000 becomes 0x80000000, and a difference above 0x7FFFFFFF becomes 0x7FFFFFFF.
- R3: After reset, the first iteration starts on the first rising clock edge with `rst_n` high. Its result raises `out_valid` on the 13th rising edge, counted from and including that one: 5 squaring stages, 7 subtract stages and 1 threshold stage.
- R4: Only one iteration is in flight at a time. While `out_ready` is held high, `out_valid` is a one-cycle pulse that recurs every 13 clocks.
- R5: `bit_out` is 1 when `x_out`, read as signed, is greater than or equal to the threshold (default 0), and 0 otherwise. A result of exactly 0 gives 1. A result of -1 LSB gives 0.
- R6: An iteration that starts while `seed_sel` is 0 uses `seed_x` as its operand. One that starts while `seed_sel` is 1 uses the previous result in `x_out`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `x_out` and `bit_out` hold steady and no iteration starts. On the edge that accepts the result, the next iteration starts, and its result becomes valid 12 edges later.
- R8: `map_r` and `seed_x` are sampled only at the edge that starts an iteration. Changes made while an iteration is in flight do not affect its result.
- R9: During reset, `out_valid`, `x_out` and `bit_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_sel | input | 1 | 0: next iteration loads the seed; 1: next iteration uses the previous result |
| seed_x | input | 32 | Seed value, signed Q4.28 |
| map_r | input | 32 | Map parameter r, signed Q4.28 |
| out_valid | output | 1 | A new iterate and its bit are presented |
| out_ready | input | 1 | Consumer accepts the presented result |
| x_out | output | 32 | Latest iterate, signed Q4.28 |
| bit_out | output | 1 | Threshold bit of the latest iterate |

## Verification
The bench builds the block with its default parameters: a 32-bit word with 28 fraction bits, 5 squaring stages, 7 subtract stages and a zero threshold. With these values the thirteen-clock cadence can be counted edge by edge. The seed 0.111 with r = 1.69 yields one iterate on each side of the threshold within the first two steps. Exact zero and one-LSB results are easy to reach, so the boundary of the greater-or-equal comparison is exercised directly. A seed near 7.9 drives the square past the top of the Q4.28 range. With r at the most negative code, the difference clips at the bottom of that range, so both saturation paths are exercised.

// File: rtl/qm_pkg.sv
package qm_pkg;
  localparam int unsigned QM_W     = 32;
  localparam int unsigned QM_FRAC  = 28;
  localparam int unsigned QM_MUL_N = 5;
  localparam int unsigned QM_SUB_N = 7;

  typedef logic signed [QM_W-1:0] qm_word_t;
endpackage

// File: rtl/qm_delay.sv
module qm_delay #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [W-1:0]     in_data,
  output logic             out_vld,
  output logic [W-1:0]     out_data,
  output logic [DEPTH-1:0] vld_tap
);
  logic [W-1:0]     d_q [DEPTH];
  logic [DEPTH-1:0] v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else begin
      v_q[0] <= in_vld;
      for (int i = 1; i < int'(DEPTH); i++) begin
        v_q[i] <= v_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    d_q[0] <= in_data;
    for (int i = 1; i < int'(DEPTH); i++) begin
      d_q[i] <= d_q[i-1];
    end
  end

  assign out_vld  = v_q[DEPTH-1];
  assign out_data = d_q[DEPTH-1];
  assign vld_tap  = v_q;
endmodule

// File: rtl/qm_square_pipe.sv
module qm_square_pipe #(
  parameter int unsigned W      = 32,
  parameter int unsigned FRAC   = 28,
  parameter int unsigned STAGES = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic signed [W-1:0] in_x,
  output logic                out_vld,
  output logic signed [W-1:0] out_sq,
  output logic signed [W-1:0] opnd_q,
  output logic [STAGES-1:0]   vld_tap
);
  localparam int unsigned PW   = 2 * W;
  localparam int unsigned TAIL = STAGES - 2;
  localparam logic signed [PW-1:0] RND_ADD = PW'(1) << (FRAC - 1);
  localparam logic signed [PW-1:0] TOP_POS = {{W{1'b0}}, 1'b0, {(W-1){1'b1}}};

  logic                 v1_q, v2_q;
  logic signed [W-1:0]  a_q;
  logic signed [PW-1:0] prod_q;
  logic signed [PW-1:0] rnd;
  logic signed [W-1:0]  sq_d;
  logic [W-1:0]         tail_out;
  logic [TAIL-1:0]      tail_tap;

  // stage 1: operand register, stage 2: full product
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= in_vld;
      v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      prod_q <= '0;
    end else begin
      if (in_vld) a_q <= in_x;
      prod_q <= a_q * a_q;
    end
  end

  // round to the working format, clip at the top (product is never negative)
  always_comb begin
    rnd = (prod_q + RND_ADD) >>> FRAC;
    if (rnd > TOP_POS) sq_d = {1'b0, {(W-1){1'b1}}};
    else               sq_d = rnd[W-1:0];
  end

  qm_delay #(.W(W), .DEPTH(TAIL)) u_tail (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (v2_q),
    .in_data  (sq_d),
    .out_vld  (out_vld),
    .out_data (tail_out),
    .vld_tap  (tail_tap)
  );

  assign out_sq  = signed'(tail_out);
  assign opnd_q  = a_q;
  assign vld_tap = {tail_tap, v2_q, v1_q};
endmodule

// File: rtl/qm_subtract_pipe.sv
module qm_subtract_pipe #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic signed [W-1:0] in_r,
  input  logic signed [W-1:0] in_sq,
  output logic                out_vld,
  output logic signed [W-1:0] out_x,
  output logic [STAGES-1:0]   vld_tap
);
  localparam int unsigned TAIL = STAGES - 2;

  logic                v1_q, v2_q;
  logic signed [W:0]   diff_q;
  logic signed [W-1:0] sat_q;
  logic [W-1:0]        tail_out;
  logic [TAIL-1:0]     tail_tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      diff_q <= '0;
      sat_q  <= '0;
    end else begin
      v1_q   <= in_vld;
      v2_q   <= v1_q;
      diff_q <= {in_r[W-1], in_r} - {in_sq[W-1], in_sq};
      if (diff_q[W] != diff_q[W-1])
        sat_q <= diff_q[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      else
        sat_q <= diff_q[W-1:0];
    end
  end

  qm_delay #(.W(W), .DEPTH(TAIL)) u_tail (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (v2_q),
    .in_data  (sat_q),
    .out_vld  (out_vld),
    .out_data (tail_out),
    .vld_tap  (tail_tap)
  );

  assign out_x   = signed'(tail_out);
  assign vld_tap = {tail_tap, v2_q, v1_q};
endmodule

// File: rtl/qm_chaos_bitgen.sv
module qm_chaos_bitgen #(
  parameter int unsigned W     = qm_pkg::QM_W,
  parameter int unsigned FRAC  = qm_pkg::QM_FRAC,
  parameter int unsigned MUL_N = qm_pkg::QM_MUL_N,
  parameter int unsigned SUB_N = qm_pkg::QM_SUB_N,
  parameter logic signed [W-1:0] THRESH = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_sel,
  input  logic [W-1:0] seed_x,
  input  logic [W-1:0] map_r,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] x_out,
  output logic         bit_out
);
  localparam int unsigned NV  = MUL_N + SUB_N;
  localparam int unsigned LAT = NV + 1;

  logic [MUL_N-1:0]    mul_vld;
  logic [SUB_N-1:0]    sub_vld;
  logic [NV-1:0]       pipe_vld;
  logic                launch;
  logic signed [W-1:0] opnd;
  logic signed [W-1:0] opnd_q;
  logic signed [W-1:0] r_hold;
  logic                sq_vld, res_vld;
  logic signed [W-1:0] sq_val, res_x;

  assign pipe_vld = {sub_vld, mul_vld};
  // a new iteration starts only with an empty loop and no unaccepted result
  assign launch   = ~|pipe_vld & (~out_valid | out_ready);
  assign opnd     = seed_sel ? signed'(x_out) : signed'(seed_x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      r_hold <= '0;
    else if (launch) r_hold <= signed'(map_r);
  end

  qm_square_pipe #(.W(W), .FRAC(FRAC), .STAGES(MUL_N)) u_sq (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (launch),
    .in_x    (opnd),
    .out_vld (sq_vld),
    .out_sq  (sq_val),
    .opnd_q  (opnd_q),
    .vld_tap (mul_vld)
  );

  qm_subtract_pipe #(.W(W), .STAGES(SUB_N)) u_sub (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (sq_vld),
    .in_r    (r_hold),
    .in_sq   (sq_val),
    .out_vld (res_vld),
    .out_x   (res_x),
    .vld_tap (sub_vld)
  );

  // threshold stage and output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      x_out     <= '0;
      bit_out   <= 1'b0;
    end else if (res_vld) begin
      out_valid <= 1'b1;
      x_out     <= res_x;
      bit_out   <= (res_x >= THRESH);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/qm_chaos_bitgen_chk.sv
module qm_chaos_bitgen_chk #(
  parameter int unsigned W   = 32,
  parameter int unsigned NV  = 12,
  parameter int unsigned LAT = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          seed_sel,
  input logic [W-1:0]  seed_x,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  x_out,
  input logic          bit_out,
  input logic          launch,
  input logic [W-1:0]  opnd_q,
  input logic [NV-1:0] pipe_vld
);
  localparam int unsigned CW = $clog2(LAT + 2);
  logic [CW-1:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         lat_cnt <= '0;
    else if (launch)                    lat_cnt <= CW'(1);
    else if (lat_cnt != 0 && !out_valid) lat_cnt <= lat_cnt + CW'(1);
  end

  assert_one_token_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pipe_vld, out_valid}));

  assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_cnt == CW'(LAT));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(x_out) && $stable(bit_out));

  assert_seed_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch && !seed_sel |=> opnd_q == $past(seed_x));

  assert_feedback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch && seed_sel |=> opnd_q == $past(x_out));

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(out_valid) |-> $stable(x_out));
endmodule

bind qm_chaos_bitgen qm_chaos_bitgen_chk #(.W(W), .NV(NV), .LAT(LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .seed_sel  (seed_sel),
  .seed_x    (seed_x),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .x_out     (x_out),
  .bit_out   (bit_out),
  .launch    (launch),
  .opnd_q    (opnd_q),
  .pipe_vld  (pipe_vld)
);

// File: tb/test_qm_chaos_bitgen.sv
module test_qm_chaos_bitgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_sel = 1'b0;
  logic [31:0] seed_x = '0;
  logic [31:0] map_r = '0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [31:0] x_out;
  logic        bit_out;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  qm_chaos_bitgen i_qm_chaos_bitgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_sel  (seed_sel),
    .seed_x    (seed_x),
    .map_r     (map_r),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .x_out     (x_out),
    .bit_out   (bit_out)
  );

  function automatic logic [31:0] to_fix(input real v);
    return 32'($rtoi(v * 268435456.0 + 0.5));
  endfunction

  // reference step from R1 and R2
  function automatic logic [31:0] ref_step(input logic [31:0] x, input logic [31:0] r);
    longint p, d;
    p = longint'($signed(x)) * longint'($signed(x));
    p = (p + 64'sd134217728) >>> 28;
    if (p > 64'sd2147483647) p = 64'sd2147483647;
    d = longint'($signed(r)) - p;
    if (d > 64'sd2147483647) d = 64'sd2147483647;
    if (d < -64'sd2147483648) d = -64'sd2147483648;
    return d[31:0];
  endfunction

  function automatic logic ref_bit(input logic [31:0] x);
    return ($signed(x) >= 0);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid", longint'(out_valid), 0);
    check(x_out == 32'h0, "R9 x_out", longint'(x_out), 0);
    check(bit_out == 1'b0, "R9 bit_out", longint'(bit_out), 0);
    rst_n = 1'b1;
  endtask

  // counts rising edges until out_valid is seen at a falling edge
  task automatic wait_result(output int n);
    n = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end while (!out_valid && n < 100);
  endtask

  task automatic test_first_iterates();
    int n;
    logic [31:0] s, r, e;
    real xr;
    s = to_fix(0.111);
    r = to_fix(1.69);
    seed_x = s; map_r = r; seed_sel = 1'b0; out_ready = 1'b1;
    do_reset();
    wait_result(n);
    check(n == 13, "R3 first latency", n, 13);
    e = ref_step(s, r);
    check(x_out == e, "R1 first iterate", longint'(x_out), longint'(e));
    xr = $itor($signed(x_out)) / 268435456.0;
    check(xr > 1.677678 && xr < 1.677680, "R1 first iterate near 1.677679",
          longint'($rtoi(xr * 1.0e6)), 1677679);
    check(bit_out == 1'b1, "R5 first bit", longint'(bit_out), 1);
    seed_sel = 1'b1;
    for (int i = 0; i < 5; i++) begin
      e = ref_step(e, r);
      wait_result(n);
      check(n == 13, "R4 cadence", n, 13);
      check(x_out == e, "R6 feedback iterate", longint'(x_out), longint'(e));
      check(bit_out == ref_bit(e), "R5 iterate bit", longint'(bit_out), longint'(ref_bit(e)));
    end
  endtask

  task automatic test_seed_hold();
    int n;
    logic [31:0] s, r, e;
    s = to_fix(0.25);
    r = to_fix(1.4);
    seed_x = s; map_r = r; seed_sel = 1'b0; out_ready = 1'b1;
    do_reset();
    e = ref_step(s, r);
    for (int i = 0; i < 2; i++) begin
      wait_result(n);
      check(x_out == e, "R6 seed reloaded while select low", longint'(x_out), longint'(e));
    end
  endtask

  task automatic test_backpressure();
    int n;
    logic [31:0] s, r, e, held;
    s = to_fix(0.111);
    r = to_fix(1.69);
    seed_x = s; map_r = r; seed_sel = 1'b0; out_ready = 1'b0;
    do_reset();
    wait_result(n);
    held = x_out;
    seed_sel = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1 && x_out == held, "R7 result held", longint'(x_out), longint'(held));
    end
    out_ready = 1'b1;
    e = ref_step(held, r);
    wait_result(n);
    check(n == 13, "R7 next result after accept", n, 13);
    check(x_out == e, "R7 value after stall", longint'(x_out), longint'(e));
  endtask

  task automatic test_param_ignore();
    int n;
    logic [31:0] s, r, e;
    s = to_fix(0.5);
    r = to_fix(1.2);
    seed_x = s; map_r = r; seed_sel = 1'b0; out_ready = 1'b1;
    do_reset();
    repeat (4) @(negedge clk);
    map_r = to_fix(0.3);
    seed_x = to_fix(0.9);
    e = ref_step(s, r);
    wait_result(n);
    check(n == 9, "R8 latency unchanged", n, 9);
    check(x_out == e, "R8 mid-flight change ignored", longint'(x_out), longint'(e));
    e = ref_step(to_fix(0.9), to_fix(0.3));
    wait_result(n);
    check(x_out == e, "R8 new inputs used at next start", longint'(x_out), longint'(e));
  endtask

  task automatic run_one(input logic [31:0] s, input logic [31:0] r, input string tag);
    int n;
    logic [31:0] e;
    seed_x = s; map_r = r; seed_sel = 1'b0; out_ready = 1'b1;
    do_reset();
    e = ref_step(s, r);
    wait_result(n);
    check(x_out == e, tag, longint'(x_out), longint'(e));
    check(bit_out == ref_bit(e), tag, longint'(bit_out), longint'(ref_bit(e)));
  endtask

  task automatic test_saturation();
    run_one(to_fix(7.9), 32'h8000_0000, "R2 both saturate");
    check(x_out == 32'h8000_0000, "R2 bottom clip", longint'(x_out), 64'h8000_0000);
    run_one(to_fix(7.9), to_fix(7.5), "R2 square clip");
    check(x_out == 32'hF800_0001, "R2 square clip value", longint'(x_out), 64'hF800_0001);
  endtask

  task automatic test_threshold_edges();
    run_one(32'h0, 32'h0, "R5 zero result");
    check(bit_out == 1'b1, "R5 zero gives one", longint'(bit_out), 1);
    run_one(32'h0000_4000, 32'h0, "R5 minus one lsb");
    check(x_out == 32'hFFFF_FFFF && bit_out == 1'b0, "R5 minus one lsb gives zero",
          longint'(x_out), 64'hFFFF_FFFF);
    run_one(32'h0000_5A82, 32'h0, "R1 rounding up");
    check(x_out == 32'hFFFF_FFFE, "R1 rounds to nearest", longint'(x_out), 64'hFFFF_FFFE);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_first_iterates();
    test_seed_hold();
    test_backpressure();
    test_param_ignore();
    test_saturation();
    test_threshold_edges();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule